// File: doc/BRIEF.md
# Infrared Receive Pulse Capture Timer

This block measures the widths of pulses arriving on an infrared receive line. An up-counter advances once for every IR input clock, signalled by a one-cycle `tick` strobe. When the timer is disabled, the counter holds a programmed start value. The receive line is first passed through a synchronizer. A chosen edge of the synchronized line (rising, falling or either) then copies the live count into a capture register and sets a sticky capture flag.

Software selects how the counter behaves at a capture. In one setting the counter restarts from zero at each capture, so the next captured value is the pulse or gap width directly. In the other setting the counter free-runs, and widths are found by subtracting consecutive captures. A wrap of the counter from its all-ones value to zero is reported through a separate sticky overflow flag. Each flag can be routed to a single registered interrupt line through its own enable.

Top module: `ir_rx_capture_timer`

## Requirements
- R1: After a synchronous reset, `cap_value` is 0 and `cap_flag`, `ovf_flag` and `irq` are all 0.
- R2: While `en` is 0, the counter holds `init_val`. While `en` is 1, it advances by one on each cycle where `tick` is 1 and holds on cycles where `tick` is 0.
- R3: `rx_in` passes through a two-stage synchronizer. A capture caused by a change on `rx_in` first shows on `cap_value` and `cap_flag` after the third rising clock edge that follows the change.
- R4: `edge_sel` selects the capture edge: 2'b00 means no capture, 2'b01 means rising edges only, 2'b10 means falling edges only, and 2'b11 means both edges.
- R5: On a capture, `cap_value` receives the count as it stood in the capture cycle, before that cycle's reload or increment.
- R6: With `clr_on_cap` set to 1, a capture reloads the counter with 0. With `tick` held high, a pulse lasting H clock cycles between two captured edges yields a second capture of H-1.
- R7: With `clr_on_cap` set to 0, captures do not disturb the counter. With `tick` held high, two captures H cycles apart differ by exactly H.
- R8: A tick that takes the count from 0xFFFF to 0x0000 sets `ovf_flag`. The flag stays set until a cycle with `ovf_clr` high. A reload at a capture counts as no wrap.
- R9: Each capture sets `cap_flag`, which stays set until a cycle with `cap_clr` high. If a capture and a clear fall in the same cycle, the set wins.
- R10: `irq` is registered. It equals (`cap_flag` AND `cap_ie`) OR (`ovf_flag` AND `ovf_ie`), using the values of the enables from the previous cycle. With both enables low, `irq` is 0.
- R11: While `en` is 0, edges on `rx_in` cause no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Timer enable; low holds the counter at `init_val` |
| tick | input | 1 | One-cycle strobe per IR input clock |
| rx_in | input | 1 | Asynchronous infrared receive line |
| edge_sel | input | 2 | Capture edge choice (off, rising, falling, both) |
| clr_on_cap | input | 1 | Restart counter from zero on each capture |
| init_val | input | 16 | Counter start value loaded while disabled |
| cap_ie | input | 1 | Capture interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| cap_clr | input | 1 | Write-one-to-clear strobe for `cap_flag` |
| ovf_clr | input | 1 | Write-one-to-clear strobe for `ovf_flag` |
| cap_value | output | 16 | Count latched at the last capture |
| cap_flag | output | 1 | Sticky capture flag |
| ovf_flag | output | 1 | Sticky counter wrap flag |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench uses four kinds of pulse on `rx_in`.

- Short and long pulses in restart mode show that widths come out as H-1 from zero.
- A pulse in free-running mode shows that a capture does not disturb the count.
- A rise while `tick` is held low shows that `init_val` is loaded and that counting depends on `tick`.
- The same rise-then-fall pulse is replayed under each `edge_sel` code and with the timer disabled. This separates rising-only, falling-only, both and off.

A start value just below the wrap point places the overflow on a known cycle. Toggling the interrupt enables around that overflow distinguishes flag masking from flag storage.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_t;
endpackage

// File: rtl/ir_rx_edge.sv
module ir_rx_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       rx_in,
  input  logic [1:0] edge_sel,
  output logic       cap_evt
);
  import ir_cap_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rx_s;
  logic                   rise, fall;
  edge_mode_t             mode;

  // synchronizer chain, one flop per stage
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= rx_in;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign rx_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= rx_s;
  end

  assign rise = rx_s & ~prev_q;
  assign fall = ~rx_s & prev_q;
  assign mode = edge_mode_t'(edge_sel);

  always_comb begin
    unique case (mode)
      EDGE_RISE: cap_evt = en & rise;
      EDGE_FALL: cap_evt = en & fall;
      EDGE_BOTH: cap_evt = en & (rise | fall);
      default:   cap_evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/ir_cap_counter.sv
module ir_cap_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             cap_evt,
  input  logic             clr_on_cap,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] count,
  output logic             ovf_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic reload;

  assign reload  = cap_evt & clr_on_cap;
  // a wrap only counts when the increment actually happens
  assign ovf_evt = en & tick & ~reload & (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst)         count <= '0;
    else if (!en)    count <= init_val;
    else if (reload) count <= '0;
    else if (tick)   count <= count + 1'b1;
  end
endmodule

// File: rtl/ir_cap_flags.sv
module ir_cap_flags #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_evt,
  input  logic             ovf_evt,
  input  logic [CNT_W-1:0] count,
  input  logic             cap_clr,
  input  logic             ovf_clr,
  input  logic             cap_ie,
  input  logic             ovf_ie,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_flag,
  output logic             ovf_flag,
  output logic             irq
);
  logic cap_n, ovf_n;

  // set has priority over the clear strobe
  assign cap_n = cap_evt | (cap_flag & ~cap_clr);
  assign ovf_n = ovf_evt | (ovf_flag & ~ovf_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_value <= '0;
      cap_flag  <= 1'b0;
      ovf_flag  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (cap_evt) cap_value <= count;
      cap_flag <= cap_n;
      ovf_flag <= ovf_n;
      irq      <= (cap_n & cap_ie) | (ovf_n & ovf_ie);
    end
  end
endmodule

// File: rtl/ir_rx_capture_timer.sv
module ir_rx_capture_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             rx_in,
  input  logic [1:0]       edge_sel,
  input  logic             clr_on_cap,
  input  logic [CNT_W-1:0] init_val,
  input  logic             cap_ie,
  input  logic             ovf_ie,
  input  logic             cap_clr,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_flag,
  output logic             ovf_flag,
  output logic             irq
);
  logic             cap_evt;
  logic             ovf_evt;
  logic [CNT_W-1:0] count;

  ir_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .en(en), .rx_in(rx_in),
    .edge_sel(edge_sel), .cap_evt(cap_evt)
  );

  ir_cap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .cap_evt(cap_evt),
    .clr_on_cap(clr_on_cap), .init_val(init_val),
    .count(count), .ovf_evt(ovf_evt)
  );

  ir_cap_flags #(.CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst(rst), .cap_evt(cap_evt), .ovf_evt(ovf_evt),
    .count(count), .cap_clr(cap_clr), .ovf_clr(ovf_clr),
    .cap_ie(cap_ie), .ovf_ie(ovf_ie), .cap_value(cap_value),
    .cap_flag(cap_flag), .ovf_flag(ovf_flag), .irq(irq)
  );
endmodule

// File: rtl/ir_rx_capture_timer_chk.sv
module ir_rx_capture_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             clr_on_cap,
  input logic [CNT_W-1:0] init_val,
  input logic             cap_ie,
  input logic             ovf_ie,
  input logic             ovf_clr,
  input logic             cap_evt,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cap_value,
  input logic             cap_flag,
  input logic             ovf_flag,
  input logic             irq
);
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> count == $past(init_val)); // R2
  AST_CAP_VALUE: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> cap_value == $past(count)); // R5
  AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && clr_on_cap && en) |=> count == '0); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R8
  AST_CAP_SET: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> cap_flag); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (!cap_ie && !ovf_ie) |=> !irq); // R10
  AST_NO_CAP_DISABLED: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_flag) |-> $past(en)); // R11
endmodule

bind ir_rx_capture_timer ir_rx_capture_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .clr_on_cap(clr_on_cap),
  .init_val(init_val), .cap_ie(cap_ie), .ovf_ie(ovf_ie),
  .ovf_clr(ovf_clr), .cap_evt(cap_evt), .count(count),
  .cap_value(cap_value), .cap_flag(cap_flag), .ovf_flag(ovf_flag),
  .irq(irq)
);

// File: tb/ir_rx_capture_timer_bench.sv
module ir_rx_capture_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0, tick = 1'b0, rx_in = 1'b0;
  logic [1:0]  edge_sel = 2'b11;
  logic        clr_on_cap = 1'b0;
  logic [15:0] init_val = '0;
  logic        cap_ie = 1'b0, ovf_ie = 1'b0, cap_clr = 1'b0, ovf_clr = 1'b0;
  logic [15:0] cap_value;
  logic        cap_flag, ovf_flag, irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ir_rx_capture_timer u_ir_rx_capture_timer (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .rx_in(rx_in),
    .edge_sel(edge_sel), .clr_on_cap(clr_on_cap), .init_val(init_val),
    .cap_ie(cap_ie), .ovf_ie(ovf_ie), .cap_clr(cap_clr), .ovf_clr(ovf_clr),
    .cap_value(cap_value), .cap_flag(cap_flag), .ovf_flag(ovf_flag),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk); cap_clr = 1'b1; ovf_clr = 1'b1;
    @(negedge clk); cap_clr = 1'b0; ovf_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cap_value", cap_value, 0);
    chk("R1 cap_flag", cap_flag, 0);
    chk("R1 ovf_flag", ovf_flag, 0);
    chk("R1 irq", irq, 0);
  endtask

  // tick held low: capture shows the loaded start value
  task automatic t_init_hold();
    en = 1'b0; tick = 1'b0; clr_on_cap = 1'b0; edge_sel = 2'b01;
    init_val = 16'h1234;
    wait_n(2);
    en = 1'b1;
    wait_n(4);
    rx_in = 1'b1;
    wait_n(2);
    chk("R3 flag not yet", cap_flag, 0);
    wait_n(1);
    chk("R3 flag at third edge", cap_flag, 1);
    chk("R2 init held without tick", cap_value, 16'h1234);
    rx_in = 1'b0;
    wait_n(4);
    clear_flags();
    chk("R9 cap_flag cleared", cap_flag, 0);
  endtask

  task automatic t_restart(input int h);
    en = 1'b1; tick = 1'b1; clr_on_cap = 1'b1; edge_sel = 2'b11;
    wait_n(2);
    rx_in = 1'b1;
    wait_n(h);
    rx_in = 1'b0;
    wait_n(3);
    chk("R6 restart width", cap_value, h - 1);
    wait_n(2);
    clear_flags();
  endtask

  task automatic t_freerun(input int h);
    logic [15:0] a;
    en = 1'b1; tick = 1'b1; clr_on_cap = 1'b0; edge_sel = 2'b11;
    wait_n(2);
    rx_in = 1'b1;
    wait_n(3);
    a = cap_value;
    wait_n(h - 3);
    rx_in = 1'b0;
    wait_n(3);
    chk("R7 free-run difference", cap_value - a, h);
    chk("R5 R7 count kept running", (cap_value != h - 1), 1);
    wait_n(2);
    clear_flags();
  endtask

  // one pulse per mode; report flag after rise and after fall
  task automatic t_edge_mode(input logic [1:0] sel, input logic exp_r,
                             input logic exp_f, input logic ena, input string req);
    en = ena; tick = 1'b1; edge_sel = sel; clr_on_cap = 1'b0;
    wait_n(2);
    rx_in = 1'b1;
    wait_n(4);
    chk({req, " after rise"}, cap_flag, exp_r);
    clear_flags();
    rx_in = 1'b0;
    wait_n(4);
    chk({req, " after fall"}, cap_flag, exp_f);
    clear_flags();
  endtask

  task automatic t_overflow();
    en = 1'b0; tick = 1'b0; clr_on_cap = 1'b0; edge_sel = 2'b00;
    init_val = 16'hFFFD; ovf_ie = 1'b0; cap_ie = 1'b0;
    wait_n(2);
    en = 1'b1; tick = 1'b1;
    wait_n(2);
    chk("R8 no wrap at FFFF", ovf_flag, 0);
    wait_n(1);
    chk("R8 wrap sets flag", ovf_flag, 1);
    chk("R10 irq masked", irq, 0);
    ovf_ie = 1'b1;
    wait_n(1);
    chk("R10 irq after enable", irq, 1);
    wait_n(5);
    chk("R8 flag sticky", ovf_flag, 1);
    clear_flags();
    chk("R8 flag cleared", ovf_flag, 0);
    chk("R10 irq drops", irq, 0);
    en = 1'b0; ovf_ie = 1'b0;
    wait_n(2);
  endtask

  task automatic t_cap_irq();
    en = 1'b1; tick = 1'b1; edge_sel = 2'b01; cap_ie = 1'b1;
    wait_n(2);
    rx_in = 1'b1;
    wait_n(2);
    chk("R10 irq before capture", irq, 0);
    wait_n(1);
    chk("R10 capture irq", irq, 1);
    rx_in = 1'b0;
    wait_n(4);
    clear_flags();
    chk("R10 capture irq cleared", irq, 0);
    cap_ie = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    t_reset();
    t_init_hold();
    t_restart(5);
    t_restart(20);
    t_freerun(12);
    t_edge_mode(2'b01, 1'b1, 1'b0, 1'b1, "R4 rising only");
    t_edge_mode(2'b10, 1'b0, 1'b1, 1'b1, "R4 falling only");
    t_edge_mode(2'b11, 1'b1, 1'b1, 1'b1, "R4 both");
    t_edge_mode(2'b00, 1'b0, 1'b0, 1'b1, "R4 off");
    t_edge_mode(2'b11, 1'b0, 1'b0, 1'b0, "R11 disabled");
    t_overflow();
    t_cap_irq();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule